// File: doc/BRIEF.md
# Read-Priority Request Arbiter with Batched Write Drain

This block sits at the front of a memory controller and decides whether the command scheduler is handed a read or a write next. Reads and writes arrive on separate enqueue ports and are held in two independent FIFO buffers. Reads are served by default because a program stalls on them. Writes collect in their own buffer and are served in batches, so that the cost of reversing the data bus direction is paid once per batch rather than once per write.

A batch (a drain) starts when writes are waiting and either no read is pending or the write buffer has filled up. Once a drain has started it hands out a minimum number of writes before reads may take over again, even if reads arrive meanwhile. The only exception is a write buffer that runs empty first. Beyond the minimum, the drain continues for as long as no read is waiting. When a drain ends, a fixed turnaround gap passes with nothing issued, and then read service resumes. The current mode is visible on a two-bit output. Requests leave through a valid/ready handshake that carries the payload and a write flag.

Top module: `rw_mode_arbiter`

## Requirements
- R1: After reset `arb_mode` is 0 (read service), `issue_valid` is low and both full flags are low.
- R2: Each buffer is first-in first-out. `issue_data` is the oldest entry of the buffer being served. `issue_is_write` is 0 in mode 0 and 1 in mode 1.
- R3: `rd_buf_full` is high exactly when the read buffer holds RD_DEPTH entries (default 30), and `wr_buf_full` is high exactly when the write buffer holds WR_DEPTH entries (default 16). An enqueue while full is ignored and no stored entry is lost or overwritten.
- R4: In mode 0, `issue_valid` is high whenever a read is stored. The mode becomes 1 (drain) in the cycle after a mode-0 cycle in which the write buffer is non-empty and the read buffer is either empty or the write buffer is full.
- R5: A drain issues at least DRAIN_MIN writes (default 4) before it ends, whatever reads are pending, unless the write buffer becomes empty first.
- R6: Once DRAIN_MIN writes have been issued, the drain continues while no read is stored, and it ends in the cycle after a cycle with a stored read.
- R7: When a drain ends, `arb_mode` is 2 (turnaround) for exactly TURN_GAP cycles (default 4) with `issue_valid` low, and then it returns to 0. A read therefore follows the last write of a drain by at least TURN_GAP empty cycles.
- R8: An entry leaves its buffer only in a cycle with `issue_valid` and `issue_ready` both high. While `issue_ready` is low in read service, the same head entry stays on `issue_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req_valid | input | 1 | Enqueue a read request |
| rd_req_data | input | DW | Read request payload |
| rd_buf_full | output | 1 | Read buffer full; enqueue is ignored |
| wr_req_valid | input | 1 | Enqueue a write request |
| wr_req_data | input | DW | Write request payload |
| wr_buf_full | output | 1 | Write buffer full; enqueue is ignored |
| issue_valid | output | 1 | A request is offered to the scheduler |
| issue_ready | input | 1 | Scheduler accepts the offered request |
| issue_is_write | output | 1 | Offered request is a write |
| issue_data | output | DW | Offered request payload |
| arb_mode | output | 2 | 0 read service, 1 write drain, 2 turnaround |

## Verification
An enqueue is seen one clock later: the full flags, the head on `issue_data` and `issue_valid` all update at the edge that stores the entry. A mode change follows one edge after the cycle whose buffer levels trigger it. The turnaround holds for TURN_GAP cycles after the edge that ends the drain. The bench drives inputs on the falling edge and compares every output a few nanoseconds later against a cycle model that steps through the same edges. Because of this, each expected value belongs to the cycle in which the design registers it. Directed sequences count the writes issued and the turnaround cycles seen at the ports between one read and the next.

// File: rtl/rwarb_pkg.sv
package rwarb_pkg;
    typedef enum logic [1:0] {
        MODE_READ  = 2'd0,
        MODE_DRAIN = 2'd1,
        MODE_TURN  = 2'd2
    } arb_mode_e;
endpackage

// File: rtl/req_fifo.sv
module req_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [DW-1:0]                push_data,
    input  logic                         pop,
    output logic [DW-1:0]                head,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         full,
    output logic                         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] rptr;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    assign full    = (st_q.cnt == CW'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem_q[st_q.rptr];
    assign level   = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (push_ok)
            st_d.wptr = (st_q.wptr == PW'(DEPTH - 1)) ? '0 : st_q.wptr + 1'b1;
        if (pop_ok)
            st_d.rptr = (st_q.rptr == PW'(DEPTH - 1)) ? '0 : st_q.rptr + 1'b1;
        if (push_ok && !pop_ok)
            st_d.cnt = st_q.cnt + 1'b1;
        else if (pop_ok && !push_ok)
            st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wptr] <= push_data;
    end
endmodule

// File: rtl/mode_ctrl.sv
module mode_ctrl
    import rwarb_pkg::*;
#(
    parameter int WCW       = 5,
    parameter int DRAIN_MIN = 4,
    parameter int TURN_GAP  = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rd_empty,
    input  logic           wr_empty,
    input  logic           wr_full,
    input  logic [WCW-1:0] wr_level,
    input  logic           wr_push_ok,
    input  logic           wr_pop_ok,
    output arb_mode_e      mode
);
    localparam int NW = $clog2(DRAIN_MIN + 1);
    localparam int TW = (TURN_GAP > 1) ? $clog2(TURN_GAP) : 1;

    typedef struct packed {
        arb_mode_e     mode;
        logic [NW-1:0] done_cnt;
        logic [TW-1:0] gap_tmr;
    } ctl_st_t;

    ctl_st_t st_d, st_q;
    logic [WCW:0] wr_after;
    logic         min_met;

    assign mode     = st_q.mode;
    assign wr_after = {1'b0, wr_level} + (wr_push_ok ? 1'b1 : 1'b0) - (wr_pop_ok ? 1'b1 : 1'b0);

    always_comb begin
        st_d    = st_q;
        min_met = 1'b0;
        unique case (st_q.mode)
            MODE_READ: begin
                st_d.done_cnt = '0;
                if (!wr_empty && (rd_empty || wr_full))
                    st_d.mode = MODE_DRAIN;
            end
            MODE_DRAIN: begin
                if (wr_pop_ok && (st_q.done_cnt != NW'(DRAIN_MIN)))
                    st_d.done_cnt = st_q.done_cnt + 1'b1;
                min_met = (st_d.done_cnt == NW'(DRAIN_MIN));
                if ((wr_after == '0) || (min_met && !rd_empty)) begin
                    st_d.mode    = MODE_TURN;
                    st_d.gap_tmr = TW'(TURN_GAP - 1);
                end
            end
            MODE_TURN: begin
                if (st_q.gap_tmr == '0) st_d.mode = MODE_READ;
                else                    st_d.gap_tmr = st_q.gap_tmr - 1'b1;
            end
            default: st_d.mode = MODE_READ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MODE_READ, done_cnt: '0, gap_tmr: '0};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rw_mode_arbiter.sv
module rw_mode_arbiter
    import rwarb_pkg::*;
#(
    parameter int DW        = 16,
    parameter int RD_DEPTH  = 30,
    parameter int WR_DEPTH  = 16,
    parameter int DRAIN_MIN = 4,
    parameter int TURN_GAP  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req_valid,
    input  logic [DW-1:0] rd_req_data,
    output logic          rd_buf_full,
    input  logic          wr_req_valid,
    input  logic [DW-1:0] wr_req_data,
    output logic          wr_buf_full,
    output logic          issue_valid,
    input  logic          issue_ready,
    output logic          issue_is_write,
    output logic [DW-1:0] issue_data,
    output logic [1:0]    arb_mode
);
    localparam int RCW = $clog2(RD_DEPTH + 1);
    localparam int WCW = $clog2(WR_DEPTH + 1);

    arb_mode_e     mode;
    logic [DW-1:0] rd_head, wr_head;
    logic [RCW-1:0] rd_level;
    logic [WCW-1:0] wr_level;
    logic          rd_empty, wr_empty;
    logic          rd_pop, wr_pop;
    logic          wr_push_ok;

    assign rd_pop     = issue_ready && (mode == MODE_READ) && !rd_empty;
    assign wr_pop     = issue_ready && (mode == MODE_DRAIN) && !wr_empty;
    assign wr_push_ok = wr_req_valid && !wr_buf_full;

    req_fifo #(.DW(DW), .DEPTH(RD_DEPTH)) u_rd_buf (
        .clk(clk), .rst_n(rst_n),
        .push(rd_req_valid), .push_data(rd_req_data), .pop(rd_pop),
        .head(rd_head), .level(rd_level), .full(rd_buf_full), .empty(rd_empty)
    );

    req_fifo #(.DW(DW), .DEPTH(WR_DEPTH)) u_wr_buf (
        .clk(clk), .rst_n(rst_n),
        .push(wr_req_valid), .push_data(wr_req_data), .pop(wr_pop),
        .head(wr_head), .level(wr_level), .full(wr_buf_full), .empty(wr_empty)
    );

    mode_ctrl #(.WCW(WCW), .DRAIN_MIN(DRAIN_MIN), .TURN_GAP(TURN_GAP)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .rd_empty(rd_empty), .wr_empty(wr_empty), .wr_full(wr_buf_full),
        .wr_level(wr_level), .wr_push_ok(wr_push_ok), .wr_pop_ok(wr_pop),
        .mode(mode)
    );

    always_comb begin
        issue_valid    = 1'b0;
        issue_is_write = 1'b0;
        issue_data     = rd_head;
        unique case (mode)
            MODE_READ:  issue_valid = !rd_empty;
            MODE_DRAIN: begin
                issue_valid    = !wr_empty;
                issue_is_write = 1'b1;
                issue_data     = wr_head;
            end
            default: issue_valid = 1'b0;
        endcase
    end

    assign arb_mode = mode;
endmodule

// File: rtl/rw_arb_checker.sv
module rw_arb_checker #(
    parameter int DW        = 16,
    parameter int RCW       = 5,
    parameter int WCW       = 5,
    parameter int RD_DEPTH  = 30,
    parameter int DRAIN_MIN = 4,
    parameter int TURN_GAP  = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [1:0]     arb_mode,
    input logic           issue_valid,
    input logic           issue_ready,
    input logic           issue_is_write,
    input logic [DW-1:0]  issue_data,
    input logic           wr_buf_full,
    input logic [RCW-1:0] rd_level,
    input logic [WCW-1:0] wr_level
);
    localparam int NW = $clog2(DRAIN_MIN + 1);
    localparam int GW = $clog2(TURN_GAP + 2);

    logic [NW-1:0] seen_q;
    logic [GW-1:0] turn_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q     <= '0;
            turn_run_q <= '0;
        end else begin
            if (arb_mode != 2'd1)
                seen_q <= '0;
            else if (issue_valid && issue_ready && (seen_q != NW'(DRAIN_MIN)))
                seen_q <= seen_q + 1'b1;
            if (arb_mode == 2'd2)
                turn_run_q <= turn_run_q + 1'b1;
            else
                turn_run_q <= '0;
        end
    end

    AST_TURN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_mode == 2'd2) |-> !issue_valid); // R7

    AST_TURN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        ((arb_mode != 2'd2) && (turn_run_q != '0)) |-> (turn_run_q == GW'(TURN_GAP))); // R7

    AST_DRAIN_WRITES_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && (arb_mode == 2'd1)) |-> issue_is_write); // R2

    AST_MIN_BATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_mode == 2'd1) |=> ((arb_mode == 2'd1) || (seen_q == NW'(DRAIN_MIN)) || (wr_level == '0))); // R5

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !issue_ready && (arb_mode == 2'd0) && !wr_buf_full)
        |=> (issue_valid && $stable(issue_data) && !issue_is_write)); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_level <= RCW'(RD_DEPTH)); // R3
endmodule

bind rw_mode_arbiter rw_arb_checker #(
    .DW(DW), .RCW(RCW), .WCW(WCW), .RD_DEPTH(RD_DEPTH),
    .DRAIN_MIN(DRAIN_MIN), .TURN_GAP(TURN_GAP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .arb_mode(arb_mode),
    .issue_valid(issue_valid), .issue_ready(issue_ready),
    .issue_is_write(issue_is_write), .issue_data(issue_data),
    .wr_buf_full(wr_buf_full), .rd_level(rd_level), .wr_level(wr_level)
);

// File: tb/tb_rw_mode_arbiter.sv
module tb_rw_mode_arbiter;
    localparam int DW = 16;
    localparam int RDD = 30;
    localparam int WRD = 16;
    localparam int DMIN = 4;
    localparam int GAP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_req_valid = 1'b0, wr_req_valid = 1'b0, issue_ready = 1'b0;
    logic [DW-1:0] rd_req_data = '0, wr_req_data = '0;
    logic rd_buf_full, wr_buf_full, issue_valid, issue_is_write;
    logic [DW-1:0] issue_data;
    logic [1:0] arb_mode;

    always #10 clk = ~clk;

    rw_mode_arbiter #(.DW(DW), .RD_DEPTH(RDD), .WR_DEPTH(WRD), .DRAIN_MIN(DMIN), .TURN_GAP(GAP)) dut (
        .clk(clk), .rst_n(rst_n),
        .rd_req_valid(rd_req_valid), .rd_req_data(rd_req_data), .rd_buf_full(rd_buf_full),
        .wr_req_valid(wr_req_valid), .wr_req_data(wr_req_data), .wr_buf_full(wr_buf_full),
        .issue_valid(issue_valid), .issue_ready(issue_ready),
        .issue_is_write(issue_is_write), .issue_data(issue_data), .arb_mode(arb_mode)
    );

    int nchk = 0, nfail = 0;
    bit finished = 0;
    logic [DW-1:0] mrq[$];
    logic [DW-1:0] mwq[$];
    int mstate = 0, mcnt = 0, mtmr = 0;
    int n_wfire = 0, n_rfire = 0, n_turn = 0;
    logic [DW-1:0] rd_seq = 16'h0001, wr_seq = 16'h8001;

    task automatic chk(input bit ok, input string tag, input string what, input int got, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, got, exp, $time);
        end
    endtask

    function automatic string mode_tag();
        if (mstate == 2 || arb_mode == 2'd2) return "R7";
        if (mstate == 1 && mcnt >= DMIN) return "R6";
        if (mstate == 1) return "R5";
        return "R4";
    endfunction

    task automatic step(input bit rp, input bit wp, input bit rdy);
        bit e_valid, fire, rfull, wfull;
        int rsz, wsz;
        logic [DW-1:0] e_data;
        @(negedge clk);
        rd_req_valid = rp; rd_req_data = rd_seq;
        wr_req_valid = wp; wr_req_data = wr_seq;
        issue_ready = rdy;
        #2;
        rsz = mrq.size(); wsz = mwq.size();
        rfull = (rsz == RDD); wfull = (wsz == WRD);
        e_valid = (mstate == 0) ? (rsz != 0) : (mstate == 1) ? (wsz != 0) : 1'b0;
        e_data = (mstate == 0 && rsz != 0) ? mrq[0] : (mstate == 1 && wsz != 0) ? mwq[0] : '0;
        chk(arb_mode == 2'(mstate), mode_tag(), "mode", arb_mode, mstate);
        chk(issue_valid == e_valid, (mstate == 0) ? "R4" : (mstate == 1) ? "R5" : "R7", "issue_valid", issue_valid, e_valid);
        chk(rd_buf_full == rfull, "R3", "rd_buf_full", rd_buf_full, rfull);
        chk(wr_buf_full == wfull, "R3", "wr_buf_full", wr_buf_full, wfull);
        if (e_valid) begin
            chk(issue_data == e_data, "R2", "issue_data", issue_data, e_data);
            chk(issue_is_write == (mstate == 1), "R2", "issue_is_write", issue_is_write, mstate == 1);
        end
        if (issue_valid && issue_ready) begin
            if (issue_is_write) n_wfire++; else n_rfire++;
        end
        if (arb_mode == 2'd2) n_turn++;
        fire = e_valid && rdy;
        if (fire && mstate == 0) void'(mrq.pop_front());
        if (fire && mstate == 1) void'(mwq.pop_front());
        if (rp && !rfull) begin mrq.push_back(rd_seq); rd_seq++; end
        if (wp && !wfull) begin mwq.push_back(wr_seq); wr_seq++; end
        case (mstate)
            0: begin
                mcnt = 0;
                if (wsz != 0 && (rsz == 0 || wfull)) mstate = 1;
            end
            1: begin
                if (fire && mcnt < DMIN) mcnt++;
                if (mwq.size() == 0 || (mcnt == DMIN && rsz != 0)) begin
                    mstate = 2; mtmr = GAP - 1;
                end
            end
            default: begin
                if (mtmr == 0) mstate = 0; else mtmr--;
            end
        endcase
    endtask

    task automatic clear_counts();
        n_wfire = 0; n_rfire = 0; n_turn = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] first_head;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(arb_mode == 2'd0, "R1", "reset mode", arb_mode, 0);
        chk(issue_valid == 1'b0, "R1", "reset issue_valid", issue_valid, 0);
        chk(rd_buf_full == 1'b0 && wr_buf_full == 1'b0, "R1", "reset full flags", {rd_buf_full, wr_buf_full}, 0);
        rst_n = 1'b1;

        // R5/R7: reads pending during a drain do not cut it short
        for (int i = 0; i < 6; i++) step(0, 1, 0);
        for (int i = 0; i < 2; i++) step(1, 0, 0);
        clear_counts();
        for (int i = 0; i < 60 && n_rfire == 0; i++) step(0, 0, 1);
        chk(n_wfire == DMIN, "R5", "writes before first read", n_wfire, DMIN);
        chk(n_turn == GAP, "R7", "turnaround cycles", n_turn, GAP);
        for (int i = 0; i < 40; i++) step(0, 0, 1);

        // R3/R6: overfilled write buffer, one continuous drain with no reads
        for (int i = 0; i < WRD + 1; i++) step(0, 1, 0);
        chk(wr_buf_full == 1'b1, "R3", "wr_buf_full after overfill", wr_buf_full, 1);
        clear_counts();
        for (int i = 0; i < 40; i++) step(0, 0, 1);
        chk(n_wfire == WRD, "R3", "writes kept after overfill", n_wfire, WRD);
        chk(n_turn == GAP, "R6", "single drain turnarounds", n_turn, GAP);

        // R3/R8: overfilled read buffer under stall
        for (int i = 0; i < RDD + 1; i++) step(1, 0, 0);
        chk(rd_buf_full == 1'b1, "R3", "rd_buf_full after overfill", rd_buf_full, 1);
        first_head = issue_data;
        step(0, 0, 0); step(0, 0, 0);
        chk(issue_data == first_head && issue_valid, "R8", "head held during stall", issue_data, first_head);
        clear_counts();
        for (int i = 0; i < 40; i++) step(0, 0, 1);
        chk(n_rfire == RDD, "R3", "reads kept after overfill", n_rfire, RDD);

        // random phases
        for (int ph = 0; ph < 4; ph++) begin
            int pr, pw, py;
            case (ph)
                0: begin pr = 50; pw = 20; py = 90; end
                1: begin pr = 10; pw = 60; py = 80; end
                2: begin pr = 70; pw = 70; py = 50; end
                default: begin pr = 30; pw = 30; py = 100; end
            endcase
            for (int i = 0; i < 800; i++)
                step(($urandom % 100) < pr, ($urandom % 100) < pw, ($urandom % 100) < py);
        end
        for (int i = 0; i < 80; i++) step(0, 0, 1);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule